// File: doc/BRIEF.md
# Floating-point register stack file

This block holds eight 80-bit registers that software addresses relative to a moving top-of-stack pointer. ST(0) is the top and ST(i) is the entry i places below it. Pushing or popping moves the pointer, so every ST(i) is renamed and no data is copied. Each physical entry carries a tag bit that marks it empty or valid. The block performs loads, pops, non-popping stores, exchanges and the write-back of results for two-operand operations. The arithmetic unit lives elsewhere: it reads operands from the two combinational read ports and returns its result on `result_i`.

A two-state controller governs the block. `S_COLD` is entered on reset. In this state every command except initialize is ignored. The initialize command moves `S_COLD` to `S_RUN`. In `S_RUN` an initialize command re-initializes and stays in `S_RUN`, and every other command is executed. Each command takes one clock cycle. A command that would overflow or underflow the stack changes nothing and raises a one-cycle flag instead.

Top module: `fstk_top`

## Requirements
- R1: After reset the block is in `S_COLD` (`ready_o`=0, `top_o`=0, all tags empty). Commands other than INIT (`op_i`=1) have no effect there. INIT sets `top_o` to 0, marks all eight tags empty, clears both flags and sets `ready_o`.
- R2: PUSH (`op_i`=2) decrements the top pointer modulo 8 and places `load_data_i` in the new ST(0) with its tag valid, so the former ST(i) becomes ST(i+1).
- R3: A PUSH while ST(7) is valid changes neither pointer, tags nor data. It sets `overflow_o` for exactly the one cycle after the command.
- R4: POP (`op_i`=3) presents the value to be stored on `st0_o` during the command cycle. It then marks that entry empty and increments the pointer, so the former ST(i) becomes ST(i-1).
- R5: POP or STORE with an empty ST(0) changes nothing and sets `underflow_o` for the one cycle after the command.
- R6: STORE (`op_i`=4) presents ST(0) on `st0_o` and leaves pointer, tags and data unchanged, with no flag raised.
- R7: XCHG (`op_i`=5) swaps the contents of ST(0) and ST(`idx_i`).
- R8: WR0 (`op_i`=6) writes `result_i` to ST(0). WRI (`op_i`=7) writes `result_i` to ST(`idx_i`). Neither moves the pointer.
- R9: WRIP (`op_i`=8) writes `result_i` to ST(`idx_i`) and then pops, so the result is found at ST(`idx_i`-1).
- R10: XCHG, WR0, WRI or WRIP with ST(0) or ST(`idx_i`) empty changes nothing and sets `underflow_o` for one cycle.
- R11: `st0_o`/`st0_valid_o` and `sti_o`/`sti_valid_o` show the entry at physical index (top+0) and (top+`idx_i`) mod 8 combinationally, within the same cycle as a change of `idx_i`.
- R12: `overflow_o` and `underflow_o` are never high together, and any later command (including NOP, `op_i`=0) clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Command code |
| idx_i | input | 3 | Relative index i for ST(i) |
| load_data_i | input | 80 | Value pushed by PUSH |
| result_i | input | 80 | Result written by WR0, WRI, WRIP |
| st0_o | output | 80 | Contents of ST(0) |
| sti_o | output | 80 | Contents of ST(i) |
| st0_valid_o | output | 1 | Tag of ST(0) |
| sti_valid_o | output | 1 | Tag of ST(i) |
| top_o | output | 3 | Physical index of ST(0) |
| tag_o | output | 8 | Tags by physical index |
| ready_o | output | 1 | High in `S_RUN` |
| overflow_o | output | 1 | One-cycle stack-overflow flag |
| underflow_o | output | 1 | One-cycle stack-underflow flag |

## Verification
The hardest case to reach is a full stack wrapped around the pointer: the top is back at physical 0, and the overflow must leave all eight renamed entries intact. The stimulus pushes eight distinct values after INIT and then a ninth. It then moves `idx_i` between clock edges to read the deepest entries through the combinational port. The combined write-and-pop case is reached by a vector sequence that first exchanges and overwrites entries, so that ST(i-1) after the pop holds a value no other path could have produced.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_INIT  = 4'd1,
        OP_PUSH  = 4'd2,
        OP_POP   = 4'd3,
        OP_STORE = 4'd4,
        OP_XCHG  = 4'd5,
        OP_WR0   = 4'd6,
        OP_WRI   = 4'd7,
        OP_WRIP  = 4'd8
    } fstk_op_e;

    typedef enum logic {
        S_COLD,
        S_RUN
    } fstk_state_e;

    // source of a register write
    typedef enum logic [1:0] {
        SRC_LOAD,
        SRC_RES,
        SRC_ST0,
        SRC_STI
    } fstk_src_e;

endpackage

// File: rtl/fstk_ctrl.sv
module fstk_ctrl
    import fstk_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [AW-1:0]    idx_i,
    input  logic [DEPTH-1:0] tag_i,
    output logic [AW-1:0]    top_o,
    output logic             ready_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             wa_en_o,
    output logic [AW-1:0]    wa_addr_o,
    output fstk_src_e        wa_src_o,
    output logic             wb_en_o,
    output logic [AW-1:0]    wb_addr_o,
    output fstk_src_e        wb_src_o,
    output logic             tag_set_o,
    output logic             tag_clr_o,
    output logic             tag_clr_all_o
);

    fstk_state_e   state_q, state_d;
    logic [AW-1:0] top_q, top_d;
    logic          ovf_q, ovf_d, unf_q, unf_d;
    fstk_op_e      op;
    logic [AW-1:0] p_i, p_m1;
    logic          v0, vi, v7, both;

    assign op   = fstk_op_e'(op_i);
    assign p_i  = top_q + idx_i;
    assign p_m1 = top_q - 1'b1;
    assign v0   = tag_i[top_q];
    assign vi   = tag_i[p_i];
    assign v7   = tag_i[p_m1];
    assign both = v0 && vi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_COLD;
        else        state_q <= state_d;
    end

    // pointer and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            top_q <= top_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    // next state and command decode
    always_comb begin
        state_d       = state_q;
        top_d         = top_q;
        ovf_d         = 1'b0;
        unf_d         = 1'b0;
        wa_en_o       = 1'b0;
        wa_addr_o     = top_q;
        wa_src_o      = SRC_RES;
        wb_en_o       = 1'b0;
        wb_addr_o     = p_i;
        wb_src_o      = SRC_ST0;
        tag_set_o     = 1'b0;
        tag_clr_o     = 1'b0;
        tag_clr_all_o = 1'b0;
        unique case (state_q)
            S_COLD: begin
                if (op == OP_INIT) begin
                    state_d       = S_RUN;
                    top_d         = '0;
                    tag_clr_all_o = 1'b1;
                end
            end
            S_RUN: begin
                unique case (op)
                    OP_INIT: begin
                        top_d         = '0;
                        tag_clr_all_o = 1'b1;
                    end
                    OP_PUSH: begin
                        if (v7) ovf_d = 1'b1;
                        else begin
                            wa_en_o   = 1'b1;
                            wa_addr_o = p_m1;
                            wa_src_o  = SRC_LOAD;
                            tag_set_o = 1'b1;
                            top_d     = p_m1;
                        end
                    end
                    OP_POP: begin
                        if (!v0) unf_d = 1'b1;
                        else begin
                            tag_clr_o = 1'b1;
                            top_d     = top_q + 1'b1;
                        end
                    end
                    OP_STORE: unf_d = !v0;
                    OP_XCHG: begin
                        if (!both) unf_d = 1'b1;
                        else begin
                            wa_en_o  = 1'b1;
                            wa_src_o = SRC_STI;
                            wb_en_o  = 1'b1;
                        end
                    end
                    OP_WR0: begin
                        if (!both) unf_d = 1'b1;
                        else wa_en_o = 1'b1;
                    end
                    OP_WRI, OP_WRIP: begin
                        if (!both) unf_d = 1'b1;
                        else begin
                            wa_en_o   = 1'b1;
                            wa_addr_o = p_i;
                            if (op == OP_WRIP) begin
                                tag_clr_o = 1'b1;
                                top_d     = top_q + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            default: state_d = S_COLD;
        endcase
    end

    // outputs
    always_comb begin
        top_o   = top_q;
        ready_o = (state_q == S_RUN);
        ovf_o   = ovf_q;
        unf_o   = unf_q;
    end

endmodule

// File: rtl/fstk_regs.sv
module fstk_regs
    import fstk_pkg::*;
#(
    parameter  int W     = 80,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    top_i,
    input  logic [AW-1:0]    idx_i,
    input  logic             wa_en_i,
    input  logic [AW-1:0]    wa_addr_i,
    input  logic [W-1:0]     wa_data_i,
    input  logic             wb_en_i,
    input  logic [AW-1:0]    wb_addr_i,
    input  logic [W-1:0]     wb_data_i,
    input  logic             tag_set_i,
    input  logic             tag_clr_i,
    input  logic             tag_clr_all_i,
    output logic [W-1:0]     rd0_o,
    output logic [W-1:0]     rdi_o,
    output logic [DEPTH-1:0] tag_o
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] p_i;

    assign p_i = top_i + idx_i;

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[k]   <= '0;
                tag_o[k] <= 1'b0;
            end else begin
                if (wa_en_i && wa_addr_i == AW'(k))      mem[k] <= wa_data_i;
                else if (wb_en_i && wb_addr_i == AW'(k)) mem[k] <= wb_data_i;
                if (tag_clr_all_i)                         tag_o[k] <= 1'b0;
                else if (tag_clr_i && top_i == AW'(k))     tag_o[k] <= 1'b0;
                else if (tag_set_i && wa_addr_i == AW'(k)) tag_o[k] <= 1'b1;
            end
        end
    end

    assign rd0_o = mem[top_i];
    assign rdi_o = mem[p_i];

endmodule

// File: rtl/fstk_top.sv
module fstk_top
    import fstk_pkg::*;
#(
    parameter  int W     = 80,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [AW-1:0]    idx_i,
    input  logic [W-1:0]     load_data_i,
    input  logic [W-1:0]     result_i,
    output logic [W-1:0]     st0_o,
    output logic [W-1:0]     sti_o,
    output logic             st0_valid_o,
    output logic             sti_valid_o,
    output logic [AW-1:0]    top_o,
    output logic [DEPTH-1:0] tag_o,
    output logic             ready_o,
    output logic             overflow_o,
    output logic             underflow_o
);

    logic          wa_en, wb_en, tag_set, tag_clr, tag_clr_all;
    logic [AW-1:0] wa_addr, wb_addr, p_i;
    fstk_src_e     wa_src, wb_src;
    logic [W-1:0]  wa_data, wb_data;

    fstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .tag_i(tag_o),
        .top_o(top_o), .ready_o(ready_o), .ovf_o(overflow_o), .unf_o(underflow_o),
        .wa_en_o(wa_en), .wa_addr_o(wa_addr), .wa_src_o(wa_src),
        .wb_en_o(wb_en), .wb_addr_o(wb_addr), .wb_src_o(wb_src),
        .tag_set_o(tag_set), .tag_clr_o(tag_clr), .tag_clr_all_o(tag_clr_all)
    );

    function automatic logic [W-1:0] pick(fstk_src_e s);
        unique case (s)
            SRC_LOAD: pick = load_data_i;
            SRC_RES:  pick = result_i;
            SRC_ST0:  pick = st0_o;
            default:  pick = sti_o;
        endcase
    endfunction

    assign wa_data = pick(wa_src);
    assign wb_data = pick(wb_src);

    fstk_regs #(.W(W), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .top_i(top_o), .idx_i(idx_i),
        .wa_en_i(wa_en), .wa_addr_i(wa_addr), .wa_data_i(wa_data),
        .wb_en_i(wb_en), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
        .tag_set_i(tag_set), .tag_clr_i(tag_clr), .tag_clr_all_i(tag_clr_all),
        .rd0_o(st0_o), .rdi_o(sti_o), .tag_o(tag_o)
    );

    assign p_i         = top_o + idx_i;
    assign st0_valid_o = tag_o[top_o];
    assign sti_valid_o = tag_o[p_i];

endmodule

// File: rtl/fstk_chk.sv
module fstk_chk
    import fstk_pkg::*;
#(
    parameter  int W     = 80,
    parameter  int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [W-1:0]     load_data_i,
    input logic [W-1:0]     st0_o,
    input logic             st0_valid_o,
    input logic [AW-1:0]    top_o,
    input logic [DEPTH-1:0] tag_o,
    input logic             ready_o,
    input logic             overflow_o,
    input logic             underflow_o
);

    assert_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_INIT |=> ready_o && top_o == '0 && tag_o == '0 && !overflow_o && !underflow_o);

    assert_cold_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && op_i != OP_INIT) |=> !ready_o && $stable(top_o) && $stable(tag_o));

    assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && op_i == OP_PUSH) |=> overflow_o ||
            (top_o == AW'($past(top_o) - 1'b1) && st0_valid_o && st0_o == $past(load_data_i)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $stable(top_o) && $stable(tag_o));

    assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && op_i == OP_POP) |=> underflow_o || top_o == AW'($past(top_o) + 1'b1));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> $stable(top_o) && $stable(tag_o));

    assert_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow_o && underflow_o));

endmodule

bind fstk_top fstk_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_fstk_top.sv
module sim_fstk_top;
    import fstk_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [2:0]  idx_i = 3'd0;
    logic [79:0] load_data_i = '0, result_i = '0;
    logic [79:0] st0_o, sti_o;
    logic        st0_valid_o, sti_valid_o, ready_o, overflow_o, underflow_o;
    logic [2:0]  top_o;
    logic [7:0]  tag_o;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fstk_top u0 (.*);

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  idx;
        logic [15:0] din;
        logic [2:0]  top;
        logic [15:0] st0;
        logic [15:0] sti;
        logic        v0;
        logic        ovf;
        logic        unf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 3'd0, 16'h11, 3'd0, 16'h00, 16'h00, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 cold push ignored
        '{4'd1, 3'd0, 16'h00, 3'd0, 16'h00, 16'h00, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 init
        '{4'd4, 3'd0, 16'h00, 3'd0, 16'h00, 16'h00, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 store empty
        '{4'd2, 3'd0, 16'h11, 3'd7, 16'h11, 16'h11, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{4'd2, 3'd0, 16'h22, 3'd6, 16'h22, 16'h22, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{4'd2, 3'd0, 16'h33, 3'd5, 16'h33, 16'h33, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{4'd5, 3'd2, 16'h00, 3'd5, 16'h11, 16'h33, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 xchg
        '{4'd6, 3'd1, 16'h44, 3'd5, 16'h44, 16'h22, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 wr0
        '{4'd7, 3'd2, 16'h55, 3'd5, 16'h44, 16'h55, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 wri
        '{4'd8, 3'd1, 16'h66, 3'd6, 16'h66, 16'h55, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 wrip
        '{4'd6, 3'd3, 16'h77, 3'd6, 16'h66, 16'h00, 1'b1, 1'b0, 1'b1, 4'd10}, // R10 empty operand
        '{4'd3, 3'd0, 16'h00, 3'd7, 16'h55, 16'h55, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 pop
        '{4'd3, 3'd0, 16'h00, 3'd0, 16'h00, 16'h00, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 pop last
        '{4'd3, 3'd0, 16'h00, 3'd0, 16'h00, 16'h00, 1'b0, 1'b0, 1'b1, 4'd5}   // R5 pop empty
    };

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] op, input logic [2:0] idx, input logic [79:0] d);
        op_i = op; idx_i = idx; load_data_i = d; result_i = d;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    initial begin
        #5;
        // R1: reset state
        check("R1 reset ready", {79'd0, ready_o}, 80'd0);
        check("R1 reset top/tags", {69'd0, top_o, tag_o}, 80'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            cmd(VEC[v].op, VEC[v].idx, {64'd0, VEC[v].din});
            check($sformatf("R%0d vec%0d", VEC[v].req, v),
                  {st0_o[15:0], sti_o[15:0], top_o, st0_valid_o, overflow_o, underflow_o},
                  {VEC[v].st0, VEC[v].sti, VEC[v].top, VEC[v].v0, VEC[v].ovf, VEC[v].unf});
            @(negedge clk);
        end

        // R2 R3: fill all eight entries, then overflow
        cmd(4'd1, 3'd0, '0);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            cmd(4'd2, 3'd0, 80'h100 + 80'(k));
            @(negedge clk);
        end
        check("R2 full top", {77'd0, top_o}, 80'd0);
        check("R2 full tags", {72'd0, tag_o}, 80'hff);
        cmd(4'd2, 3'd0, 80'h1ff);
        check("R3 overflow flag", {78'd0, overflow_o, underflow_o}, 80'd2);
        check("R3 top kept", {77'd0, top_o}, 80'd0);
        check("R3 st0 kept", st0_o, 80'h107);
        @(negedge clk);
        op_i = 4'd0;
        // R11: combinational read port follows idx_i
        idx_i = 3'd7; #1;
        check("R11 sti idx7", sti_o, 80'h100);
        idx_i = 3'd3; #1;
        check("R11 sti idx3", sti_o, 80'h104);
        check("R11 sti valid", {79'd0, sti_valid_o}, 80'd1);
        // R6: store without pop, also clears the earlier flag (R12)
        cmd(4'd4, 3'd0, '0);
        check("R6 store top", {77'd0, top_o}, 80'd0);
        check("R6 store st0", st0_o, 80'h107);
        check("R12 flags cleared", {78'd0, overflow_o, underflow_o}, 80'd0);
        @(negedge clk);
        // R9 with i=0: result dropped by the pop
        cmd(4'd8, 3'd0, 80'h999);
        check("R9 wrip i0 top", {77'd0, top_o}, 80'd1);
        check("R9 wrip i0 st0", st0_o, 80'h106);
        @(negedge clk);

        // R1: reset mid-run returns to cold
        rst_n = 1'b0; #1;
        check("R1 mid reset", {68'd0, ready_o, top_o, tag_o}, 80'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        cmd(4'd2, 3'd0, 80'h5);
        check("R1 cold push", {68'd0, ready_o, top_o, tag_o}, 80'd0);
        @(negedge clk);
        finish_run();
    end

endmodule